// File: doc/BRIEF.md
# Sensorless Six-Step Commutation Timer

This block is the timing core of a spindle motor driver that runs without position sensors. It receives a cleaned-up back-EMF zero-crossing pulse, measures how many timer ticks separate successive accepted crossings, and uses that interval to schedule the next commutation. A commutation comes a programmable angle after the crossing. After each commutation, crossing detection is blanked for a window, so that switching transients are not mistaken for a crossing. The block outputs a 3-bit phase number and one-hot high-side and low-side enables for three half-bridges. In each phase, one bridge is driven high, one is driven low and one floats.

One six-step interval is 60 electrical degrees. The 30-degree delay is therefore half of the last measured interval, and the 15-degree delay is a quarter of it. The blanking window is 15 or 7.5 degrees, which is a quarter or an eighth of the interval. During acceleration, the blanking window instead takes one of four fixed times. In an external mode, a host-controlled bit steps the sequence instead of the crossings. A stuck-rotor flag rises when no crossing is accepted within a selectable timeout. All timing runs on a tick that is the system clock divided by 1, 2 or 1.5.

The controller has five states:
- IDLE: the run input is low.
- WAIT: armed and waiting for a crossing.
- DELAY: counting down the commutation delay.
- MASK: blanking after a commutation.
- EXT: host stepping.

The transitions are:
- start: IDLE to WAIT.
- crossing: WAIT to DELAY.
- commutate: DELAY to MASK.
- unblank: MASK to WAIT.
- host-take: any state to EXT while external mode is high.
- host-release: EXT to WAIT.
- stop: any state to IDLE when run is low.

Top module: `sixstep_commutator`

## Requirements
- R1: While `run` is low, `phase` is 0, every bridge floats (`hi_en` = `lo_en` = 0) and `stuck` is 0; all three also hold after reset.
- R2: While `run` is high and `out_dis` is low, the bridge enables follow `phase`. Bit 0 is bridge A, bit 1 is B and bit 2 is C. The mapping is:
  - phase 0: A high, B low
  - phase 1: A high, C low
  - phase 2: B high, C low
  - phase 3: B high, A low
  - phase 4: C high, A low
  - phase 5: C high, B low
- R3: Each commutation advances `phase` by exactly one, modulo 6.
- R4: A crossing accepted at edge A commutes at the edge of the D-th tick after A. The value P is the number of ticks from the previous accepted crossing (or from leaving IDLE) up to and including A. D is P/2 when `delay_sel`=0 and P/4 when `delay_sel`=1, rounded down, with a minimum of one tick.
- R5: After a commutation, crossings are ignored for M ticks, where M is P/4 (`mask_sel`=0) or P/8 (`mask_sel`=1), rounded down. The first tick edge after the window accepts a crossing. Crossings seen during a pending delay are ignored too. An ignored crossing does not restart the interval measurement.
- R6: While `accel` is 1, the window M is fixed by `accel_mask`: code 0 gives 4 units, 1 gives 2, 2 gives 1 and 3 gives 8 units of UNIT_TICKS ticks. With a 0.8 ms unit, these are 3.2, 1.6, 0.8 and 6.4 ms.
- R7: While `ext_mode` is 1, each 0-to-1 change of `ext_step` advances `phase` by one at the next clock edge. Holding the bit high, lowering it, or pulsing `zc_pulse` does not advance the phase.
- R8: `stuck` rises at the edge where the tick count since the last accepted crossing reaches the limit. The limit is 500 units when `stuck_sel`=0 and 125 units when it is 1. An accepted crossing, external mode, or `run` low clears the flag.
- R9: `out_dis`=1 floats all bridges at once without changing `phase`. On release, the drive resumes in the same phase.
- R10: `clk_div` sets the timing tick. Value 0 gives a tick every cycle, 1 gives a tick every second cycle, 2 gives two ticks in every three cycles, and 3 behaves as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| run | input | 1 | Enables the sequencer; low resets phase and floats bridges |
| ext_mode | input | 1 | 1 selects host stepping |
| ext_step | input | 1 | Host step bit; rising change advances in external mode |
| zc_pulse | input | 1 | Debounced back-EMF zero-crossing pulse |
| delay_sel | input | 1 | 0: 30-degree delay, 1: 15-degree delay |
| mask_sel | input | 1 | 0: 15-degree window, 1: 7.5-degree window |
| accel | input | 1 | 1 selects the fixed acceleration window |
| accel_mask | input | 2 | Fixed window code (4/2/1/8 units) |
| stuck_sel | input | 1 | 0: 500-unit timeout, 1: 125-unit timeout |
| out_dis | input | 1 | Floats all bridges |
| clk_div | input | 2 | Tick divider: /1, /2, /1.5, /1 |
| phase | output | 3 | Commutation state 0..5 |
| hi_en | output | 3 | High-side enables, bit 0 = bridge A |
| lo_en | output | 3 | Low-side enables, bit 0 = bridge A |
| stuck | output | 1 | Stuck-rotor flag |

## Verification
The bench targets these boundaries:
- The last masked tick and the first open tick of the blanking window. A window that is one tick off either accepts a transient early, which gives an early commutation with the wrong period, or drops a real crossing, which gives no commutation at all.
- Crossings inside a pending delay. A design that accepts them would shorten the delay.
- A masked crossing. A design that lets it reset the interval would produce a visibly shorter following delay.
- Zero-length delays.
- The exact edge at which `stuck` rises.
- The 1.5 divider. A design that gets the tick ratio wrong stretches or shrinks every measured interval.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DELAY,
        ST_MASK,
        ST_EXT
    } sc_state_e;

    typedef struct packed {
        logic [1:0] hi;
        logic [1:0] lo;
    } sc_pair_t;

    localparam int unsigned SC_NUM_STEPS   = 6;
    localparam int unsigned SC_NUM_BRIDGES = 3;

    function automatic logic [2:0] sc_next_phase(input logic [2:0] p);
        return (p >= 3'(SC_NUM_STEPS - 1)) ? 3'd0 : p + 3'd1;
    endfunction

    // bridge index 0 = A, 1 = B, 2 = C; index 3 means none
    function automatic sc_pair_t sc_bridge_pair(input logic [2:0] p);
        sc_pair_t r;
        case (p)
            3'd0:    r = '{hi: 2'd0, lo: 2'd1};
            3'd1:    r = '{hi: 2'd0, lo: 2'd2};
            3'd2:    r = '{hi: 2'd1, lo: 2'd2};
            3'd3:    r = '{hi: 2'd1, lo: 2'd0};
            3'd4:    r = '{hi: 2'd2, lo: 2'd0};
            3'd5:    r = '{hi: 2'd2, lo: 2'd1};
            default: r = '{hi: 2'd3, lo: 2'd3};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sc_prescaler.sv
module sc_prescaler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    output logic       tick
);

    logic [1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= 2'd0;
        end else if (cnt_q == 2'd2 || (div_sel == 2'd1 && cnt_q == 2'd1)) begin
            cnt_q <= 2'd0;
        end else begin
            cnt_q <= cnt_q + 2'd1;
        end
    end

    always_comb begin
        unique case (div_sel)
            2'd1:    tick = (cnt_q == 2'd1);
            2'd2:    tick = (cnt_q != 2'd2);
            default: tick = 1'b1;
        endcase
    end

endmodule

// File: rtl/sc_interval_meter.sv
module sc_interval_meter #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic             accept,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] meas,
    output logic [CNT_W-1:0] period,
    output logic             stuck
);

    logic [CNT_W-1:0] since_q;
    logic [CNT_W-1:0] period_q;
    logic             stuck_q;

    // ticks up to and including the current edge
    always_comb meas = since_q + (tick ? CNT_W'(1) : '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q  <= '0;
            period_q <= '0;
            stuck_q  <= 1'b0;
        end else if (clear) begin
            since_q  <= '0;
            period_q <= '0;
            stuck_q  <= 1'b0;
        end else if (accept) begin
            period_q <= meas;
            since_q  <= '0;
            stuck_q  <= 1'b0;
        end else if (tick) begin
            if (since_q < limit) since_q <= since_q + CNT_W'(1);
            if (meas >= limit)   stuck_q <= 1'b1;
        end
    end

    assign period = period_q;
    assign stuck  = stuck_q;

endmodule

// File: rtl/sc_bridge_map.sv
module sc_bridge_map
    import sc_pkg::*;
(
    input  logic                      drive_en,
    input  logic [2:0]                phase,
    output logic [SC_NUM_BRIDGES-1:0] hi_en,
    output logic [SC_NUM_BRIDGES-1:0] lo_en
);

    sc_pair_t pair;

    always_comb pair = sc_bridge_pair(phase);

    for (genvar b = 0; b < SC_NUM_BRIDGES; b++) begin : g_bridge
        assign hi_en[b] = drive_en && (pair.hi == 2'(b));
        assign lo_en[b] = drive_en && (pair.lo == 2'(b));
    end

endmodule

// File: rtl/sixstep_commutator.sv
module sixstep_commutator
    import sc_pkg::*;
#(
    parameter int unsigned UNIT_TICKS    = 16000,
    parameter int unsigned STUCK_LONG_U  = 500,
    parameter int unsigned STUCK_SHORT_U = 125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       ext_mode,
    input  logic       ext_step,
    input  logic       zc_pulse,
    input  logic       delay_sel,
    input  logic       mask_sel,
    input  logic       accel,
    input  logic [1:0] accel_mask,
    input  logic       stuck_sel,
    input  logic       out_dis,
    input  logic [1:0] clk_div,
    output logic [2:0] phase,
    output logic [2:0] hi_en,
    output logic [2:0] lo_en,
    output logic       stuck
);

    localparam int unsigned STUCK_MAX = STUCK_LONG_U * UNIT_TICKS;
    localparam int unsigned CNT_W     = $clog2(STUCK_MAX + 2);

    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(STUCK_LONG_U * UNIT_TICKS);
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(STUCK_SHORT_U * UNIT_TICKS);
    localparam logic [CNT_W-1:0] ACC_M0    = CNT_W'(4 * UNIT_TICKS);
    localparam logic [CNT_W-1:0] ACC_M1    = CNT_W'(2 * UNIT_TICKS);
    localparam logic [CNT_W-1:0] ACC_M2    = CNT_W'(1 * UNIT_TICKS);
    localparam logic [CNT_W-1:0] ACC_M3    = CNT_W'(8 * UNIT_TICKS);

    sc_state_e        state_q, state_nx;
    logic [2:0]       phase_q;
    logic [CNT_W-1:0] tmr_q;
    logic             ext_q;

    logic             tick;
    logic             accept;
    logic             meter_clear;
    logic [CNT_W-1:0] meas, period, limit;
    logic [CNT_W-1:0] delay_ticks, mask_ticks, accel_ticks;
    logic             tmr_done;

    sc_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (clk_div),
        .tick    (tick)
    );

    assign accept      = run && !ext_mode && (state_q == ST_WAIT) && zc_pulse;
    assign meter_clear = !run || ext_mode || (state_q == ST_IDLE);
    assign limit       = stuck_sel ? LIM_SHORT : LIM_LONG;

    sc_interval_meter #(.CNT_W(CNT_W)) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (meter_clear),
        .tick   (tick),
        .accept (accept),
        .limit  (limit),
        .meas   (meas),
        .period (period),
        .stuck  (stuck)
    );

    // window arithmetic: 60 degrees = one measured interval
    always_comb begin
        delay_ticks = delay_sel ? (meas >> 2) : (meas >> 1);
        unique case (accel_mask)
            2'd0:    accel_ticks = ACC_M0;
            2'd1:    accel_ticks = ACC_M1;
            2'd2:    accel_ticks = ACC_M2;
            default: accel_ticks = ACC_M3;
        endcase
        if (accel) mask_ticks = accel_ticks;
        else       mask_ticks = mask_sel ? (period >> 3) : (period >> 2);
        tmr_done = tick && (tmr_q <= CNT_W'(1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        if (!run) begin
            state_nx = ST_IDLE;
        end else if (ext_mode) begin
            state_nx = ST_EXT;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_nx = ST_WAIT;
                ST_WAIT:  if (zc_pulse) state_nx = ST_DELAY;
                ST_DELAY: if (tmr_done) state_nx = ST_MASK;
                ST_MASK:  if (tmr_done) state_nx = ST_WAIT;
                ST_EXT:   state_nx = ST_WAIT;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // phase, window timer, host-bit history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 3'd0;
            tmr_q   <= '0;
            ext_q   <= 1'b0;
        end else begin
            ext_q <= ext_step;
            if (!run) begin
                phase_q <= 3'd0;
                tmr_q   <= '0;
            end else begin
                unique case (state_q)
                    ST_WAIT: begin
                        if (accept) tmr_q <= delay_ticks;
                    end
                    ST_DELAY: begin
                        if (!ext_mode && tick) begin
                            if (tmr_done) begin
                                phase_q <= sc_next_phase(phase_q);
                                tmr_q   <= mask_ticks;
                            end else begin
                                tmr_q <= tmr_q - CNT_W'(1);
                            end
                        end
                    end
                    ST_MASK: begin
                        if (!ext_mode && tick && !tmr_done) tmr_q <= tmr_q - CNT_W'(1);
                    end
                    ST_EXT: begin
                        if (ext_mode && ext_step && !ext_q) phase_q <= sc_next_phase(phase_q);
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    assign phase = phase_q;

    sc_bridge_map u_map (
        .drive_en (run && !out_dis),
        .phase    (phase_q),
        .hi_en    (hi_en),
        .lo_en    (lo_en)
    );

endmodule

// File: rtl/sc_checker.sv
module sc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run,
    input logic       ext_mode,
    input logic       out_dis,
    input logic [2:0] phase,
    input logic [2:0] hi_en,
    input logic [2:0] lo_en,
    input logic       stuck
);

    a_r1_idle_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (phase == 3'd0 && !stuck));

    a_r2_one_high_one_low: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !out_dis) |-> ($countones(hi_en) == 1 && $countones(lo_en) == 1
                               && (hi_en & lo_en) == 3'd0));

    a_r3_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (phase <= 3'd5));

    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && phase != $past(phase))
        |-> (phase == (($past(phase) == 3'd5) ? 3'd0 : $past(phase) + 3'd1)));

    a_r8_no_stuck_in_ext: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode |=> !stuck);

    a_r9_float_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |-> (hi_en == 3'd0 && lo_en == 3'd0));

endmodule

bind sixstep_commutator sc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .ext_mode (ext_mode),
    .out_dis  (out_dis),
    .phase    (phase),
    .hi_en    (hi_en),
    .lo_en    (lo_en),
    .stuck    (stuck)
);

// File: tb/sim_sixstep_commutator.sv
module sim_sixstep_commutator;

    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0, ext_mode = 1'b0, ext_step = 1'b0, zc_pulse = 1'b0;
    logic       delay_sel = 1'b0, mask_sel = 1'b0, accel = 1'b0, stuck_sel = 1'b0, out_dis = 1'b0;
    logic [1:0] accel_mask = 2'd0, clk_div = 2'd0;
    logic [2:0] phase, hi_en, lo_en;
    logic       stuck;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sixstep_commutator #(.UNIT_TICKS(UNIT)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .ext_mode(ext_mode), .ext_step(ext_step),
        .zc_pulse(zc_pulse), .delay_sel(delay_sel), .mask_sel(mask_sel), .accel(accel),
        .accel_mask(accel_mask), .stuck_sel(stuck_sel), .out_dis(out_dis), .clk_div(clk_div),
        .phase(phase), .hi_en(hi_en), .lo_en(lo_en), .stuck(stuck)
    );

    function automatic int nxt(int p);
        return (p + 1) % 6;
    endfunction

    function automatic int exp_hi(int p);
        return (p < 2) ? 0 : (p < 4) ? 1 : 2;
    endfunction

    function automatic int exp_lo(int p);
        case (p)
            0, 5:    return 1;
            1, 2:    return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_delay(int p, bit dsel);
        int d = dsel ? p / 4 : p / 2;
        return (d < 1) ? 1 : d;
    endfunction

    function automatic int exp_mask(int p, bit msel, bit acc, int code);
        if (acc) begin
            case (code)
                0:       return 4 * UNIT;
                1:       return 2 * UNIT;
                2:       return 1 * UNIT;
                default: return 8 * UNIT;
            endcase
        end
        return msel ? p / 8 : p / 4;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_map(string tag);
        int p = int'(phase);
        check(hi_en == 3'(1 << exp_hi(p)), tag, int'(hi_en), 1 << exp_hi(p));
        check(lo_en == 3'(1 << exp_lo(p)), tag, int'(lo_en), 1 << exp_lo(p));
    endtask

    // pulse sampled n edges after the edge preceding this negedge
    task automatic zc_after(int n);
        int m = (n < 1) ? 1 : n;
        repeat (m - 1) @(negedge clk);
        zc_pulse = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0;
    endtask

    task automatic watch(int maxw, output int k);
        int old = int'(phase);
        k = -1;
        for (int i = 1; i <= maxw; i++) begin
            @(negedge clk);
            if (int'(phase) != old) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic restart(output int k);
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        run = 1'b1;
        zc_after(3);
        watch(5000, k);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        summary();
        $finish;
    end

    initial begin
        int kp, pp, k, k1, k2, k3, m, m2, old, rs;
        bit msp;
        rs = $urandom(32'd1357);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(phase == 3'd0, "R1 reset phase", int'(phase), 0);
        check(hi_en == 3'd0 && lo_en == 3'd0, "R1 reset float", int'({hi_en, lo_en}), 0);
        check(!stuck, "R1 reset stuck", int'(stuck), 0);

        run = 1'b1;
        @(negedge clk);
        check_map("R2 phase 0 map");

        // random intervals, delays and windows
        restart(kp);
        pp  = 8;
        msp = 1'b0;
        for (int it = 0; it < 40; it++) begin
            bit ds, ms;
            int t, bound, mprev;
            ds = 1'($urandom % 2);
            ms = 1'($urandom % 2);
            mprev = exp_mask(pp, msp, 1'b0, 0);
            if (mprev < 1) mprev = 1;
            bound = kp + mprev + 1;
            t = 3 + int'($urandom % 198);
            if (t < bound) t = bound;
            delay_sel = ds;
            mask_sel  = ms;
            old = int'(phase);
            zc_after(t - kp);
            watch(500, k);
            check(k == exp_delay(t, ds), "R4 delay", k, exp_delay(t, ds));
            check(int'(phase) == nxt(old), "R3 sequence", int'(phase), nxt(old));
            check_map("R2 map");
            kp  = (k < 0) ? 0 : k;
            pp  = t;
            msp = ms;
        end

        // R5: crossing in delay, crossing in window, first open edge
        begin
            int t, bound, mprev;
            mprev = exp_mask(pp, msp, 1'b0, 0);
            if (mprev < 1) mprev = 1;
            bound = kp + mprev + 1;
            t = (bound > 80) ? bound : 80;
            delay_sel = 1'b0;
            mask_sel  = 1'b0;
            zc_after(t - kp);
            zc_after(2);
            watch(500, k1);
            k = k1 + 2;
            check(k == exp_delay(t, 1'b0), "R5 crossing in delay ignored", k, exp_delay(t, 1'b0));
            m = exp_mask(t, 1'b0, 1'b0, 0);
            old = int'(phase);
            zc_after(m);
            repeat (10) @(negedge clk);
            check(int'(phase) == old, "R5 masked crossing ignored", int'(phase), old);
            zc_after(2);
            watch(500, k2);
            check(k2 == exp_delay(k + m + 12, 1'b0), "R5 interval kept", k2, exp_delay(k + m + 12, 1'b0));
            m2 = exp_mask(k + m + 12, 1'b0, 1'b0, 0);
            zc_after(m2 + 1);
            watch(500, k3);
            check(k3 == exp_delay(k2 + m2 + 1, 1'b0), "R5 first open edge", k3, exp_delay(k2 + m2 + 1, 1'b0));
            kp = (k3 < 0) ? 0 : k3;
        end

        // R6: fixed acceleration windows
        accel = 1'b1;
        for (int c = 0; c < 4; c++) begin
            int ka, kb;
            accel_mask = 2'(c);
            zc_after(100 - kp);
            watch(500, ka);
            m = exp_mask(0, 1'b0, 1'b1, c);
            old = int'(phase);
            zc_after(m);
            check(int'(phase) == old, "R6 accel window holds", int'(phase), old);
            zc_after(1);
            watch(500, kb);
            check(kb == exp_delay(ka + m + 1, 1'b0), "R6 accel window length", kb, exp_delay(ka + m + 1, 1'b0));
            kp = (kb < 0) ? 0 : kb;
        end
        accel = 1'b0;

        // R9: output disable
        old = int'(phase);
        out_dis = 1'b1;
        @(negedge clk);
        check(hi_en == 3'd0 && lo_en == 3'd0, "R9 float", int'({hi_en, lo_en}), 0);
        repeat (3) @(negedge clk);
        out_dis = 1'b0;
        @(negedge clk);
        check(int'(phase) == old, "R9 phase kept", int'(phase), old);
        check_map("R9 drive resumes");

        // R7: external stepping
        ext_mode = 1'b1;
        repeat (2) @(negedge clk);
        check(!stuck, "R8 clear in external mode", int'(stuck), 0);
        for (int i = 0; i < 4; i++) begin
            old = int'(phase);
            ext_step = 1'b1;
            @(negedge clk);
            check(int'(phase) == nxt(old), "R7 rising step", int'(phase), nxt(old));
            repeat (3) @(negedge clk);
            zc_after(1);
            check(int'(phase) == nxt(old), "R7 hold and crossing ignored", int'(phase), nxt(old));
            ext_step = 1'b0;
            @(negedge clk);
            check(int'(phase) == nxt(old), "R7 falling ignored", int'(phase), nxt(old));
        end

        // R8: stuck-rotor timing
        stuck_sel = 1'b1;
        ext_mode  = 1'b0;
        repeat (125 * UNIT - 1) @(negedge clk);
        check(!stuck, "R8 short limit early", int'(stuck), 0);
        @(negedge clk);
        check(stuck, "R8 short limit reached", int'(stuck), 1);
        stuck_sel = 1'b0;
        zc_after(1);
        check(!stuck, "R8 cleared by crossing", int'(stuck), 0);
        repeat (500 * UNIT - 1) @(negedge clk);
        check(!stuck, "R8 long limit early", int'(stuck), 0);
        @(negedge clk);
        check(stuck, "R8 long limit reached", int'(stuck), 1);

        run = 1'b0;
        repeat (2) @(negedge clk);
        check(!stuck && phase == 3'd0, "R1 stop clears", int'({stuck, phase}), 0);
        check(hi_en == 3'd0 && lo_en == 3'd0, "R1 stop floats", int'({hi_en, lo_en}), 0);

        // R10: tick divider
        clk_div = 2'd1;
        restart(kp);
        zc_after(80 - kp);
        watch(500, k);
        check(k >= 39 && k <= 40, "R10 divide by 2", k, 40);
        clk_div = 2'd2;
        restart(kp);
        zc_after(90 - kp);
        watch(500, k);
        check(k >= 44 && k <= 46, "R10 divide by 1.5", k, 45);
        clk_div = 2'd3;
        restart(kp);
        zc_after(60 - kp);
        watch(500, k);
        check(k == 30, "R10 code 3 as divide by 1", k, 30);

        summary();
        $finish;
    end

endmodule